// File: doc/BRIEF.md
# Source-Synchronous DDR Lane Serializer

This block is the transmit end of a parallel link in which every lane carries its own clock. On each rising edge of the core clock it captures a parallel word. It splits the word into byte lanes and shifts each byte out serially. The shifting uses both edges of a clock that runs at four times the core rate, so eight bits leave per core cycle.

Each lane also drives a forwarded clock. This clock is the 4x clock itself, gated by that lane's enable. The receiver can therefore sample data on both edges of the forwarded clock and needs no clock recovery. After every reset, each lane first sends a fixed alignment byte (`8'hA5`) for a number of words set by an input. It then switches to user data. The lane slice sits in a generate loop, so adding lanes changes only a parameter.

`clk_4x` must be phase-locked to `clk_core`: every core rising edge coincides with a `clk_4x` rising edge, and there are four `clk_4x` periods per core period.

Top module: `ddr_lane_tx`

## Requirements
- R1: Lane 0 carries `word_in[7:0]` on `ser_data[0]`, and lane 1 carries `word_in[15:8]` on `ser_data[1]`. Each further lane takes the next byte up.
- R2: `word_in` and `lane_en` are captured together on a `clk_core` rising edge. Bit 0 of that word's byte starts on the first `clk_4x` rising edge after the capturing edge.
- R3: Within a word, bits go out from bit 0 to bit 7, one per half period of `clk_4x`. Even bits occupy the high phases, starting at rising edges. Odd bits occupy the low phases, starting at falling edges. Words follow one another with no gap.
- R4: While a lane is enabled for a word, its `fwd_clk` equals `clk_4x` for all eight bit slots of that word.
- R5: The lane shift registers reload exactly once every four `clk_4x` cycles, which is one reload per core word.
- R6: A lane's enable applies to whole words: the enable sampled with a word governs all eight bit slots of that word, and only those.
- R7: After reset, the first `align_len` words are replaced on every enabled lane by the byte `8'hA5`, sent in the same bit order. User data follows from word number `align_len` onward. With `align_len` = 0, user data starts with the first word.
- R8: For every slot of a word in which a lane is disabled, that lane's `ser_data` stays 0 and its `fwd_clk` stays 0.
- R9: `rst_n` is asynchronous and active low. During reset, and after release until the first bit slot, all `ser_data` and `fwd_clk` outputs are 0. Each reset restarts the alignment word count.
- R10: Lanes are independent: the enable and data of one lane do not affect another lane's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock; one parallel word per rising edge |
| clk_4x | input | 1 | Bit clock at four times the core rate, phase-locked to `clk_core` |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | LANES*LANE_W | Parallel word, one byte per lane |
| lane_en | input | LANES | Per-lane enable, captured with the word |
| align_len | input | ALIGN_W | Number of alignment words sent after reset |
| ser_data | output | LANES | Serial data, one bit per lane |
| fwd_clk | output | LANES | Forwarded clock, one per lane |

## Verification
The assertions rely on three assumptions about the inputs:
- `clk_4x` and `clk_core` keep their fixed 4:1 phase-locked relation.
- `align_len` changes only while `rst_n` is low.
- Reset is released away from any clock edge.

The bench makes both clocks in one process from a single half-period count, so the phase relation cannot drift. It changes `align_len` only inside reset. It drives words, enables and the reset release at odd nanosecond times, which lie midway between edges.

// File: rtl/ddr_lane_tx.sv
module ddr_lane_tx #(
  parameter int LANES = 2,
  parameter int LANE_W = 8,
  parameter int ALIGN_W = 8,
  parameter logic [LANE_W-1:0] ALIGN_BYTE = 8'hA5
) (
  input  logic                    clk_core,
  input  logic                    clk_4x,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] word_in,
  input  logic [LANES-1:0]        lane_en,
  input  logic [ALIGN_W-1:0]      align_len,
  output logic [LANES-1:0]        ser_data,
  output logic [LANES-1:0]        fwd_clk
);
  localparam int HALF = LANE_W / 2;

  logic [LANES*LANE_W-1:0] word_q;
  logic [LANES-1:0]        en_core, en_lat, en_w;
  logic                    tog, tog_seen, reload, aligning;
  logic [ALIGN_W-1:0]      sent;

  always_ff @(posedge clk_core or negedge rst_n)
    if (!rst_n) begin
      word_q  <= '0;
      en_core <= '0;
      tog     <= 1'b0;
    end else begin
      word_q  <= word_in;
      en_core <= lane_en;
      tog     <= ~tog;
    end

  assign reload   = tog ^ tog_seen;
  assign aligning = sent < align_len;

  always_ff @(posedge clk_4x or negedge rst_n)
    if (!rst_n) begin
      tog_seen <= 1'b0;
      sent     <= '0;
      en_w     <= '0;
    end else begin
      tog_seen <= tog;
      if (reload) begin
        en_w <= en_core;
        if (aligning) sent <= sent + 1'b1;
      end
    end

  // clock gate enable moves only while clk_4x is low
  always_ff @(negedge clk_4x or negedge rst_n)
    if (!rst_n) en_lat <= '0;
    else        en_lat <= en_core;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] src;
    logic [HALF-1:0]   ev_src, od_src, ev_sh, od_sh;
    logic              rise_q, odd_nx, fall_q;

    assign src = aligning ? ALIGN_BYTE : word_q[l*LANE_W +: LANE_W];

    always_comb
      for (int i = 0; i < HALF; i++) begin
        ev_src[i] = src[2*i];
        od_src[i] = src[2*i+1];
      end

    always_ff @(posedge clk_4x or negedge rst_n)
      if (!rst_n) begin
        rise_q <= 1'b0;
        odd_nx <= 1'b0;
        ev_sh  <= '0;
        od_sh  <= '0;
      end else if (reload) begin
        rise_q <= ev_src[0];
        odd_nx <= od_src[0];
        ev_sh  <= ev_src >> 1;
        od_sh  <= od_src >> 1;
      end else begin
        rise_q <= ev_sh[0];
        odd_nx <= od_sh[0];
        ev_sh  <= ev_sh >> 1;
        od_sh  <= od_sh >> 1;
      end

    always_ff @(negedge clk_4x or negedge rst_n)
      if (!rst_n) fall_q <= 1'b0;
      else        fall_q <= odd_nx;

    assign ser_data[l] = en_w[l] & (clk_4x ? rise_q : fall_q);
    assign fwd_clk[l]  = clk_4x & en_lat[l];
  end
endmodule

// File: rtl/ddr_lane_tx_chk.sv
module ddr_lane_tx_chk #(
  parameter int LANES = 2,
  parameter int LANE_W = 8,
  parameter int ALIGN_W = 8
) (
  input logic               clk_4x,
  input logic               rst_n,
  input logic               reload,
  input logic [ALIGN_W-1:0] sent,
  input logic [ALIGN_W-1:0] align_len,
  input logic [LANES-1:0]   en_w,
  input logic [LANES-1:0]   en_lat
);
  localparam int HALF = LANE_W / 2;
  localparam int GW = $clog2(HALF) + 1;

  logic [GW-1:0] gap;
  logic          started;

  always_ff @(posedge clk_4x or negedge rst_n)
    if (!rst_n) begin
      gap     <= '0;
      started <= 1'b0;
    end else if (reload) begin
      gap     <= '0;
      started <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end

  a_r5_reload_spacing: assert property (@(posedge clk_4x) disable iff (!rst_n)
    (reload && started) |-> (gap == GW'(HALF - 1)));

  a_r5_reload_not_late: assert property (@(posedge clk_4x) disable iff (!rst_n)
    started |-> (gap <= GW'(HALF - 1)));

  a_r7_align_count_bounded: assert property (@(posedge clk_4x) disable iff (!rst_n)
    sent <= align_len);

  a_r6_enable_word_aligned: assert property (@(posedge clk_4x) disable iff (!rst_n)
    !reload |=> $stable(en_w));

  a_r8_gates_agree: assert property (@(posedge clk_4x) disable iff (!rst_n)
    !reload |-> (en_w == en_lat));
endmodule

bind ddr_lane_tx ddr_lane_tx_chk #(.LANES(LANES), .LANE_W(LANE_W), .ALIGN_W(ALIGN_W)) i_chk (
  .clk_4x(clk_4x), .rst_n(rst_n), .reload(reload), .sent(sent),
  .align_len(align_len), .en_w(en_w), .en_lat(en_lat)
);

// File: tb/test_ddr_lane_tx.sv
module test_ddr_lane_tx;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk_core = 1'b0;
  logic        clk_4x = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word_in = '0;
  logic [1:0]  lane_en = '0;
  logic [7:0]  align_len = '0;
  logic [1:0]  ser_data, fwd_clk;

  int n_chk = 0;
  int n_fail = 0;
  int next_r = 21;

  typedef struct {
    logic [1:0] d;
    logic [1:0] c;
    logic [1:0] e;
    logic       al;
  } slot_t;
  slot_t sb[$];

  ddr_lane_tx #(.LANES(2), .LANE_W(8), .ALIGN_W(8)) i_ddr_lane_tx (
    .clk_core(clk_core), .clk_4x(clk_4x), .rst_n(rst_n), .word_in(word_in),
    .lane_en(lane_en), .align_len(align_len), .ser_data(ser_data), .fwd_clk(fwd_clk)
  );

  // 250 MHz bit clock; core clock at a quarter, rising with every 4th rise
  initial begin : clkgen
    int r = 0;
    forever begin
      #2;
      clk_4x = ~clk_4x;
      if (clk_4x) begin
        r++;
        if (r % 2 == 1) clk_core = ~clk_core;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int kind, input int j);
    logic [7:0] a, b;
    case (kind)
      0: begin a = 8'(j * 29 + 3); b = 8'(~(j * 71)); return {a, b}; end
      1: case (j)
           0: return 16'hFFFF;
           1: return 16'h0000;
           2: return 16'hAAAA;
           3: return 16'h5555;
           4: return 16'h8001;
           default: return 16'h00FF;
         endcase
      default: return 16'h0F0F ^ 16'(16'h1111 * j);
    endcase
  endfunction

  function automatic logic [1:0] ens(input int kind, input int j);
    case (kind)
      0: case (j)
           1, 4: return 2'b01;
           5: return 2'b10;
           6: return 2'b00;
           default: return 2'b11;
         endcase
      1: return 2'b11;
      default: return 2'(j + 1);
    endcase
  endfunction

  task automatic session(input int align, input int nw, input int kind);
    int r = next_r;
    align_len = 8'(align);
    #(r - 2 - $time);
    for (int l = 0; l < 2; l++) begin
      chk("R9", $sformatf("lane%0d data in reset", l), ser_data[l], 1'b0);
      chk("R9", $sformatf("lane%0d fwd clock in reset", l), fwd_clk[l], 1'b0);
    end
    #2 rst_n = 1'b1;
    #4;
    for (int l = 0; l < 2; l++) begin
      chk("R9", $sformatf("lane%0d data before first slot", l), ser_data[l], 1'b0);
      chk("R9", $sformatf("lane%0d fwd clock before first slot", l), fwd_clk[l], 1'b0);
    end
    fork
      begin : drive
        for (int j = 0; j < nw; j++) begin
          logic [15:0] w;
          logic [1:0]  e;
          #(r + 6 + 16 * j - $time);
          w = pat(kind, j);
          e = ens(kind, j);
          word_in = w;
          lane_en = e;
          for (int k = 0; k < 8; k++) begin
            slot_t s;
            s.al = (j < align);
            s.e = e;
            for (int l = 0; l < 2; l++) begin
              logic [7:0] by;
              by = (j < align) ? 8'hA5 : w[8*l +: 8];
              s.d[l] = e[l] & by[k];
              s.c[l] = e[l] & (k % 2 == 0);
            end
            sb.push_back(s);
          end
        end
      end
      begin : watch
        for (int s = 0; s < 8 * nw; s++) begin
          slot_t x;
          #(r + 18 + 2 * s - $time);
          x = sb.pop_front();
          for (int l = 0; l < 2; l++) begin
            string tg;
            tg = !x.e[l] ? "R8" : (x.al ? "R7" : "R3");
            // data slot also covers R1 R2 R5 R6 R10
            chk(tg, $sformatf("lane%0d bit slot %0d data (R1 R2 R5 R6 R10)", l, s),
                ser_data[l], x.d[l]);
            chk(x.e[l] ? "R4" : "R8", $sformatf("lane%0d bit slot %0d fwd clock", l, s),
                fwd_clk[l], x.c[l]);
          end
        end
      end
    join
    #(r + 16 * nw + 20 - $time) rst_n = 1'b0;
    next_r = r + 16 * nw + 32;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    session(3, 10, 0);
    session(0, 6, 1);
    session(2, 5, 2);
    #10;
    finish_run();
  end

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end
endmodule